// File: doc/BRIEF.md
# Stage Register with Hold and Empty-Slot Injection

This block is the register that sits between two adjacent stages of a five-stage in-order processor pipeline. On each rising clock edge it does one of three things, selected by two control inputs supplied by an external hazard unit: it captures the values arriving from the upstream stage, it keeps what it already holds, or it loads a fixed empty-slot pattern. That pattern travels down the pipeline like a no-operation instruction.

The carried data is an opaque packed vector whose width is a parameter. The empty-slot pattern is a parameter too. Its default puts the no-operation opcode in the top nibble, fills every register-identifier nibble with 0xF (meaning "no register"), and sets the status nibble to the normal-running code. The control inputs are decided combinationally during one cycle and take effect at the following edge. When both control inputs are raised together, the request is contradictory. The register then holds its contents and sets a sticky error flag, which only reset clears.

Top module: `stage_reg`

## Requirements
- R1: With hold=0 and squash=0, q equals the value d had at the preceding rising edge.
- R2: With hold=1 and squash=0, q keeps its previous value across the edge, whatever d is.
- R3: With hold=0 and squash=1, q becomes EMPTY_PAT at the next edge. The default pattern is {4'h1 opcode in bits [W-1:W-4], 4'hF in every register-ID nibble, 4'h0 status in bits [3:0]}, which gives 0x1FFF0 for W=20.
- R4: A synchronous active-high rst loads EMPTY_PAT into q and clears err at the next edge.
- R5: With hold=1 and squash=1 at an edge, q keeps its previous value (hold wins) and err is 1 after that edge.
- R6: Once set, err stays 1 on every later edge until rst, whatever the control inputs do.
- R7: Mode decisions take effect one edge later: q never changes between edges, and a change in hold, squash or d affects q only at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Keep current contents |
| squash | input | 1 | Load the empty-slot pattern |
| d | input | W | Incoming stage fields |
| q | output | W | Registered stage fields |
| err | output | 1 | Sticky flag for contradictory control |

## Verification
The case that needs the most care is hold and squash arriving in the same cycle. One input asks the register to keep its value and the other asks it to overwrite it. The bench provokes this directly, and it also arises in the random phase, where both controls are drawn independently. It then checks that q equals the value held before that edge, not the empty pattern and not d, and that err rises after that same edge and stays high through later normal, hold and squash cycles until reset clears it.

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int W = 20,
  parameter logic [W-1:0] EMPTY_PAT = {4'h1, {(W-8){1'b1}}, 4'h0}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         squash,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         err
);

  logic [W-1:0] nxt;
  logic         clash;

  assign clash = hold & squash;
  assign nxt   = hold ? q : (squash ? EMPTY_PAT : d);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= EMPTY_PAT;
      err <= 1'b0;
    end else begin
      q   <= nxt;
      err <= err | clash;
    end
  end

  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  p_load_r1: assert property (@(posedge clk) disable iff (rst || !seen)
    (!hold && !squash) |=> (q == $past(d)));
  p_keep_r2: assert property (@(posedge clk) disable iff (rst || !seen)
    hold |=> $stable(q));
  p_empty_r3: assert property (@(posedge clk) disable iff (rst || !seen)
    (!hold && squash) |=> (q == EMPTY_PAT));
  p_reset_r4: assert property (@(posedge clk)
    (seen && rst) |=> (q == EMPTY_PAT && !err));
  p_flag_r5: assert property (@(posedge clk) disable iff (rst || !seen)
    (hold && squash) |=> err);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst || !seen)
    err |=> err);

endmodule

// File: tb/tb_stage_reg.sv
module tb_stage_reg;
  localparam int W = 20;
  localparam logic [W-1:0] EMPTY = 20'h1FFF0;

  logic clk = 0, rst = 1, hold = 0, squash = 0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic err;
  int checks = 0, errors = 0;
  logic [W-1:0] model_q;
  logic model_err;

  always #10 clk = ~clk;

  stage_reg #(.W(W)) dut (.clk, .rst, .hold, .squash, .d, .q, .err);

  function automatic logic [W-1:0] next_q(logic [W-1:0] cur, logic h, logic s, logic [W-1:0] din);
    if (h) return cur;
    if (s) return EMPTY;
    return din;
  endfunction

  task automatic chk(string req, logic [W-1:0] aq, logic [W-1:0] eq, logic ae, logic ee);
    checks++;
    if (aq !== eq || ae !== ee) begin
      errors++;
      $display("FAIL %s q=%h exp=%h err=%b exp=%b", req, aq, eq, ae, ee);
    end
  endtask

  task automatic step(logic h, logic s, logic [W-1:0] din, string req);
    hold = h; squash = s; d = din;
    @(posedge clk);
    model_q = next_q(model_q, h, s, din);
    model_err = model_err | (h & s);
    #5;
    chk(req, q, model_q, err, model_err);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog q=%h exp=%h", q, model_q);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #5;
    model_q = EMPTY; model_err = 0;
    chk("R4", q, EMPTY, err, 1'b0);
    rst = 0;
    step(0, 0, 20'hABCDE, "R1");
    step(0, 0, 20'h12345, "R1");
    step(1, 0, 20'h55555, "R2");
    // R7: a change between edges does not move q
    d = 20'h0F0F0; hold = 0; #3;
    chk("R7", q, model_q, err, model_err);
    step(0, 1, 20'h77777, "R3");
    step(0, 0, 20'h00001, "R1");
    step(1, 1, 20'hFFFFF, "R5");
    step(0, 0, 20'h22222, "R6");
    step(0, 1, 20'h33333, "R6");
    rst = 1; @(posedge clk); #5;
    model_q = EMPTY; model_err = 0;
    chk("R4", q, EMPTY, err, 1'b0);
    rst = 0;
    for (int i = 0; i < 400; i++) begin
      logic h, s;
      h = ($urandom % 4) == 0;
      s = ($urandom % 5) == 0;
      step(h, s, W'($urandom), h & s ? "R5" : (h ? "R2" : (s ? "R3" : "R1")));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule